// File: doc/BRIEF.md
# Flash CFI Query Mode Controller

This block is the part of a parallel NOR flash command interface that recognises the parameter query command and serves the query table. It sits on a synchronous bus with a write strobe, a read strobe, a word address and 16-bit data. It also has a busy input from the program/erase engine. Reads return one of three sources, selected by the current mode: array data (a plain input port here), identification data (also an input port), or words from a built-in parameter table.

The block can enter query mode from two places: from read-array mode while the engine is idle, and from identification mode. It records which of the two it came from, and a reset command returns it there. Identification mode is reached with a three-write unlock sequence.

Commands are decoded from the full 16-bit write data. The upper byte must be zero.

Top module: `nor_query_ctl`

## Requirements
- R1: In read-array mode with busy low, a write of 0098h to word address 055h enters query mode. Later reads at table addresses return table words.
- R2: While busy is high in read-array mode, the query command and the unlock writes are ignored. Reads keep returning array data.
- R3: A write of 0098h to 055h in identification mode enters query mode, whatever the value of busy. A reset command then returns to identification mode, where reads return id_data.
- R4: Query mode entered from read-array mode returns to read-array mode on a reset command. In query mode, every write other than the reset command leaves the mode unchanged. This includes the query command and the unlock steps.
- R5: In query mode, a read whose address has any bit at position 7 or above set returns 0000h.
- R6: The identification string in query mode is as follows. Addresses 010h, 011h and 012h return 0051h, 0052h and 0059h. Address 013h returns 0002h and 015h returns 0040h. Addresses 014h, 016h, 017h, 018h, 019h and 01Ah return 0000h.
- R7: The supply voltage words are as follows. Address 01Bh returns 0027h and 01Ch returns 0036h, with volts in bits 7..4 and tenths of a volt in bits 3..0. Addresses 01Dh and 01Eh return 0000h.
- R8: The timeout words at addresses 01Fh through 026h are, in that order: 0003h, 0000h, 000Ah, 0000h, 0005h, 0000h, 0002h, 0000h.
- R9: In query mode, a read at an address below 080h that is not in the table returns 0000h.
- R10: Identification mode is entered from read-array mode by three writes, with busy low: 00AAh to 555h, then 0055h to 2AAh, then 0090h to 555h. Any other write at the second or third step abandons the sequence, and the mode stays read-array.
- R11: A write of 00F0h to any address is the reset command. In read-array mode it leaves the mode unchanged. In identification mode it returns to read-array mode.
- R12: A query write with the wrong address or the wrong data word does not change the mode.
- R13: rdata is 0000h after reset. It takes the selected value one cycle after a cycle with rd_en high, and it holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Word address |
| wdata | input | 16 | Write data (command word) |
| busy | input | 1 | Program/erase engine busy |
| array_data | input | 16 | Array read data |
| id_data | input | 16 | Identification read data |
| rdata | output | 16 | Registered read data |

## Verification
The table is read at every implemented address and compared with values the bench computes itself. Reads at unimplemented low addresses and at addresses with high bits set separate a table-gating fault from a lookup fault.

Both entry paths are driven, and each is followed by a reset:
- The return source that the reads show tells the two paths apart.
- Command words that are nearly right test the qualification of address, data and busy: the wrong address, the wrong data, and the right command issued while busy.
- Broken unlock sequences test the qualification of the unlock steps.

Writes issued inside query mode show whether the mode holds.

// File: rtl/nqc_pkg.sv
package nqc_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_IDENT   = 2'd1,
    MODE_QUERY   = 2'd2
  } mode_e;

  localparam logic [15:0] CMD_QUERY = 16'h0098;
  localparam logic [15:0] CMD_RESET = 16'h00F0;
  localparam logic [15:0] CMD_UNLK1 = 16'h00AA;
  localparam logic [15:0] CMD_UNLK2 = 16'h0055;
  localparam logic [15:0] CMD_IDENT = 16'h0090;

  localparam int unsigned ADR_QUERY = 32'h055;
  localparam int unsigned ADR_UNLK1 = 32'h555;
  localparam int unsigned ADR_UNLK2 = 32'h2AA;

  localparam int unsigned TBL_LOW_BITS = 7;

  // Parameter table lookup on the low address bits.
  function automatic logic [15:0] cfi_word(input logic [6:0] a);
    logic [15:0] w;
    case (a)
      7'h10: w = 16'h0051;
      7'h11: w = 16'h0052;
      7'h12: w = 16'h0059;
      7'h13: w = 16'h0002;
      7'h15: w = 16'h0040;
      7'h1B: w = 16'h0027;
      7'h1C: w = 16'h0036;
      7'h1F: w = 16'h0003;
      7'h21: w = 16'h000A;
      7'h23: w = 16'h0005;
      7'h25: w = 16'h0002;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/nqc_unlock.sv
module nqc_unlock #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              enable,
  input  logic              clear,
  output logic              ident_hit
);
  import nqc_pkg::*;

  typedef enum logic [1:0] {U_IDLE, U_ONE, U_TWO} ustep_e;
  ustep_e step_q, step_d;

  logic is_step1, is_step2, is_step3, take;
  assign is_step1 = (addr == ADDR_W'(ADR_UNLK1)) && (wdata == CMD_UNLK1);
  assign is_step2 = (addr == ADDR_W'(ADR_UNLK2)) && (wdata == CMD_UNLK2);
  assign is_step3 = (addr == ADDR_W'(ADR_UNLK1)) && (wdata == CMD_IDENT);
  assign take     = wr_en && enable && !clear;

  always_comb begin
    step_d    = step_q;
    ident_hit = 1'b0;
    if (clear) begin
      step_d = U_IDLE;
    end else if (take) begin
      case (step_q)
        U_IDLE: if (is_step1) step_d = U_ONE;
        U_ONE:  step_d = is_step2 ? U_TWO : U_IDLE;
        default: begin
          step_d    = U_IDLE;
          ident_hit = is_step3;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= U_IDLE;
    else        step_q <= step_d;
  end

  AST_UNLOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == U_ONE && take && !is_step2) |=> (step_q == U_IDLE)); // R10

endmodule

// File: rtl/nqc_mode_fsm.sv
module nqc_mode_fsm (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           query_hit,
  input  logic           reset_hit,
  input  logic           ident_hit,
  input  logic           busy,
  output nqc_pkg::mode_e mode
);
  import nqc_pkg::*;

  mode_e mode_q, mode_d;
  logic  ret_ident_q, ret_ident_d;

  always_comb begin
    mode_d      = mode_q;
    ret_ident_d = ret_ident_q;
    case (mode_q)
      MODE_ARRAY: begin
        if (reset_hit) mode_d = MODE_ARRAY;
        else if (query_hit && !busy) begin
          mode_d      = MODE_QUERY;
          ret_ident_d = 1'b0;
        end else if (ident_hit) mode_d = MODE_IDENT;
      end
      MODE_IDENT: begin
        if (reset_hit) mode_d = MODE_ARRAY;
        else if (query_hit) begin
          mode_d      = MODE_QUERY;
          ret_ident_d = 1'b1;
        end
      end
      default: begin
        if (reset_hit) mode_d = ret_ident_q ? MODE_IDENT : MODE_ARRAY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_ARRAY;
      ret_ident_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      ret_ident_q <= ret_ident_d;
    end
  end

  assign mode = mode_q;

  AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARRAY && query_hit && !busy) |=> (mode_q == MODE_QUERY)); // R1
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ARRAY && busy) |=> (mode_q == MODE_ARRAY)); // R2
  AST_RETURN_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_QUERY && reset_hit && ret_ident_q) |=> (mode_q == MODE_IDENT)); // R3
  AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_QUERY && !reset_hit) |=> (mode_q == MODE_QUERY)); // R4

endmodule

// File: rtl/nqc_cfi_rom.sv
module nqc_cfi_rom #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       word
);
  import nqc_pkg::*;

  logic upper_zero;

  generate
    if (ADDR_W > TBL_LOW_BITS) begin : g_gate
      assign upper_zero = ~|addr[ADDR_W-1:TBL_LOW_BITS];
    end else begin : g_nogate
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign word = upper_zero ? cfi_word(addr[TBL_LOW_BITS-1:0]) : 16'h0000;

endmodule

// File: rtl/nor_query_ctl.sv
module nor_query_ctl #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              busy,
  input  logic [15:0]       array_data,
  input  logic [15:0]       id_data,
  output logic [15:0]       rdata
);
  import nqc_pkg::*;

  mode_e       mode;
  logic        query_hit, reset_hit, ident_hit;
  logic        unlock_en, unlock_clr;
  logic [15:0] tbl_word;

  assign query_hit  = wr_en && (addr == ADDR_W'(ADR_QUERY)) && (wdata == CMD_QUERY);
  assign reset_hit  = wr_en && (wdata == CMD_RESET);
  assign unlock_en  = !busy;
  assign unlock_clr = (mode != MODE_ARRAY) || reset_hit || query_hit;

  nqc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .enable(unlock_en), .clear(unlock_clr), .ident_hit(ident_hit)
  );

  nqc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .query_hit(query_hit), .reset_hit(reset_hit),
    .ident_hit(ident_hit), .busy(busy), .mode(mode)
  );

  nqc_cfi_rom #(.ADDR_W(ADDR_W)) u_rom (.addr(addr), .word(tbl_word));

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 16'h0000;
    else if (rd_en) begin
      case (mode)
        MODE_ARRAY: rdata <= array_data;
        MODE_IDENT: rdata <= id_data;
        default:    rdata <= tbl_word;
      endcase
    end
  end

  AST_UPPER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == MODE_QUERY && addr >= ADDR_W'(128)) |=> (rdata == 16'h0000)); // R5
  AST_QRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == MODE_QUERY && addr == ADDR_W'(16)) |=> (rdata == 16'h0051)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rdata)); // R13

endmodule

// File: tb/nor_query_ctl_test.sv
`timescale 1ns/1ps
module nor_query_ctl_test;
  localparam logic [15:0] ARR = 16'hA5C3;
  localparam logic [15:0] IDW = 16'h1C7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nor_query_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .array_data(ARR), .id_data(IDW), .rdata(rdata)
  );

  function automatic logic [15:0] exp_tbl(input int a);
    if (a >= 128) return 16'h0000;
    if (a == 'h10) return 16'h0051;
    if (a == 'h11) return 16'h0052;
    if (a == 'h12) return 16'h0059;
    if (a == 'h13 || a == 'h25) return 16'h0002;
    if (a == 'h15) return 16'h0040;
    if (a == 'h1B) return 16'h0027;
    if (a == 'h1C) return 16'h0036;
    if (a == 'h1F) return 16'h0003;
    if (a == 'h21) return 16'h000A;
    if (a == 'h23) return 16'h0005;
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic t_reset_state();
    check("R13 reset", rdata, 16'h0000);
    rd(12'h010, "R11 array after reset", ARR);
    wr(12'h123, 16'h00F0);
    rd(12'h010, "R11 reset in array", ARR);
  endtask

  task automatic t_query_array();
    wr(12'h055, 16'h0098);
    for (int a = 'h10; a <= 'h1A; a++) rd(12'(a), "R6 id string", exp_tbl(a));
    for (int a = 'h1B; a <= 'h1E; a++) rd(12'(a), "R7 voltage", exp_tbl(a));
    for (int a = 'h1F; a <= 'h26; a++) rd(12'(a), "R8 timeout", exp_tbl(a));
    rd(12'h000, "R9 unimpl 00", 16'h0000);
    rd(12'h027, "R9 unimpl 27", 16'h0000);
    rd(12'h07F, "R9 unimpl 7F", 16'h0000);
    rd(12'h090, "R5 upper bit7", 16'h0000);
    rd(12'h810, "R5 upper bit11", 16'h0000);
    wr(12'h3C4, 16'h00F0);
    rd(12'h010, "R4 back to array", ARR);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    wr(12'h055, 16'h0098);
    busy = 1'b0;
    rd(12'h010, "R2 busy query ignored", ARR);
    busy = 1'b1;
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    busy = 1'b0;
    rd(12'h010, "R2 busy unlock ignored", ARR);
  endtask

  task automatic t_wrong_cmd();
    wr(12'h0AA, 16'h0098);
    rd(12'h010, "R12 wrong address", ARR);
    wr(12'h055, 16'h0097);
    rd(12'h010, "R12 wrong data", ARR);
    wr(12'h455, 16'h0098);
    rd(12'h010, "R12 high address", ARR);
  endtask

  task automatic t_query_hold();
    wr(12'h055, 16'h0098);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    rd(12'h010, "R4 unlock in query", 16'h0051);
    wr(12'h055, 16'h0098);
    rd(12'h011, "R4 requery", 16'h0052);
    wr(12'h000, 16'h00F0);
    rd(12'h011, "R4 return array", ARR);
  endtask

  task automatic t_ident_path();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
    rd(12'h000, "R10 ident entered", IDW);
    busy = 1'b1;
    wr(12'h055, 16'h0098);
    busy = 1'b0;
    rd(12'h011, "R3 query from ident", 16'h0052);
    wr(12'h7FF, 16'h00F0);
    rd(12'h011, "R3 back to ident", IDW);
    wr(12'h001, 16'h00F0);
    rd(12'h011, "R11 ident to array", ARR);
  endtask

  task automatic t_abort();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0012); wr(12'h555, 16'h0090);
    rd(12'h000, "R10 abort step2", ARR);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0091);
    rd(12'h000, "R10 abort step3", ARR);
  endtask

  task automatic t_hold();
    wr(12'h055, 16'h0098);
    rd(12'h012, "R13 latency", 16'h0059);
    @(negedge clk); addr = 12'h010;
    @(negedge clk);
    check("R13 hold", rdata, 16'h0059);
    wr(12'h000, 16'h00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_query_array();
    t_busy();
    t_wrong_cmd();
    t_query_hold();
    t_ident_path();
    t_abort();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule